// File: doc/BRIEF.md
# Memory-Mapped GPIO Interrupt Controller

This block gives software control of up to 32 general-purpose pins over a plain 32-bit register bus. Each pin can be an input or an output. Output pins drive a level that software has written. Input pins pass through a two-stage synchronizer, and their levels can be read back over the bus.

The synchronized level of every pin feeds an interrupt detector. Each pin is set to level or edge sensing. One polarity bit per pin serves both modes. In level mode the bit picks active-high or active-low. In edge mode it picks the falling or the rising edge; there is no both-edges setting. Detected events show in a raw status register whatever the enables say. A pending register masks status with the per-pin enables, and one interrupt line is the OR of all pending bits. Software acknowledges edge events by writing ones to a clear register.

The bus has no wait states. A write takes effect at the clock edge where select and write are both high. Read data is driven combinationally from the word index on the address lines. Byte offset = 4 × word index.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is held, every register reads zero, `irq_o` is low, `pin_out` is zero and `pin_oe` is all ones, because a direction bit of 0 means output.
- R2: In the direction register (index 1, offset 0x04), bit i = 1 makes pin i an input (`pin_oe[i]` = 0) and bit i = 0 makes it an output (`pin_oe[i]` = 1). `pin_out` always shows the output-value register.
- R3: A write to the value register (index 0, offset 0x00) sets `pin_out`. A read of it returns the synchronized pin level for input pins and the driven value for output pins.
- R4: In level mode (bit i of the mode register, index 6 / offset 0x18, is 0), status bit i (index 3, offset 0x0C) is 1 while the synchronized pin equals polarity bit i (index 7, offset 0x1C; 1 = active-high, 0 = active-low). A clear does not hold it low while the level stays active.
- R5: In edge mode (mode bit = 1), polarity 0 selects the rising edge and polarity 1 the falling edge. A detected edge sets the status bit, and the bit stays set until it is cleared. An edge in the other direction does not set it.
- R6: Writing 1 to bit i of the clear register (index 5, offset 0x14) clears edge status bit i. Bits written as 0 have no effect. If an edge is detected in the same cycle as the clear, the edge wins. The clear register reads as zero.
- R7: The pending register (index 4, offset 0x10) reads as status AND enable (index 2, offset 0x08). Status is recorded even when the pin is not enabled.
- R8: `irq_o` is high exactly when some pending bit is 1.
- R9: Writes to the status and pending registers are ignored.
- R10: A pin change sampled at clock edge k is not visible in status after edge k+1 and is visible after edge k+2.
- R11: Register bits at or above `N_PINS` read as zero, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| pin_in | input | N_PINS | Raw pin levels from the pads |
| pin_out | output | N_PINS | Driven levels for output pins |
| pin_oe | output | N_PINS | Output enable per pin (1 = drive) |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is an edge event and a clear for the same pin landing on the same clock edge. That needs the bus write to commit exactly two edges after the pin change is sampled. The bench drives the pin on a falling clock edge, counts two rising edges and then issues the clear so that it commits on the edge where the detector fires. A sweep over every pin, mode and polarity also checks the status value one edge early and then on time, to pin down the synchronizer latency.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    REG_VAL  = 3'd0,
    REG_DIR  = 3'd1,
    REG_IEN  = 3'd2,
    REG_STAT = 3'd3,
    REG_PEND = 3'd4,
    REG_CLR  = 3'd5,
    REG_MODE = 3'd6,
    REG_POL  = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_in;
      stage2_q <= stage1_q;
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic cur,
  input  logic edge_mode,
  input  logic pol,
  input  logic clr,
  output logic evt,
  output logic status
);
  logic prev_q, status_q, status_d;
  logic rise, fall, lvl_hit;

  always_comb begin
    rise    = cur & ~prev_q;
    fall    = prev_q & ~cur;
    lvl_hit = pol ? cur : ~cur;
    evt     = edge_mode ? (pol ? fall : rise) : lvl_hit;
    // edge status is sticky until cleared, level status follows the pin
    status_d = (status_q & ~clr & edge_mode) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q   <= cur;
      status_q <= status_d;
    end
  end

  assign status = status_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_sync,
  input  logic [N_PINS-1:0] status,
  output logic [N_PINS-1:0] out_val,
  output logic [N_PINS-1:0] dir,
  output logic [N_PINS-1:0] ien,
  output logic [N_PINS-1:0] edge_sel,
  output logic [N_PINS-1:0] pol,
  output logic [N_PINS-1:0] clr_mask
);
  logic [N_PINS-1:0] val_q, val_d, dir_q, dir_d, ien_q, ien_d;
  logic [N_PINS-1:0] mode_q, mode_d, pol_q, pol_d;
  logic [N_PINS-1:0] wbits, lvl, pend;
  logic              wr_en;
  reg_idx_e          idx;

  function automatic logic [DATA_W-1:0] widen(input logic [N_PINS-1:0] v);
    return DATA_W'(v);
  endfunction

  assign wr_en = bus_sel & bus_wr;
  assign idx   = reg_idx_e'(bus_addr);
  assign wbits = bus_wdata[N_PINS-1:0];

  always_comb begin
    val_d    = val_q;
    dir_d    = dir_q;
    ien_d    = ien_q;
    mode_d   = mode_q;
    pol_d    = pol_q;
    clr_mask = '0;
    if (wr_en) begin
      case (idx)
        REG_VAL:  val_d    = wbits;
        REG_DIR:  dir_d    = wbits;
        REG_IEN:  ien_d    = wbits;
        REG_CLR:  clr_mask = wbits;
        REG_MODE: mode_d   = wbits;
        REG_POL:  pol_d    = wbits;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      dir_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      val_q  <= val_d;
      dir_q  <= dir_d;
      ien_q  <= ien_d;
      mode_q <= mode_d;
      pol_q  <= pol_d;
    end
  end

  assign lvl  = (dir_q & pin_sync) | (~dir_q & val_q);
  assign pend = status & ien_q;

  always_comb begin
    case (idx)
      REG_VAL:  bus_rdata = widen(lvl);
      REG_DIR:  bus_rdata = widen(dir_q);
      REG_IEN:  bus_rdata = widen(ien_q);
      REG_STAT: bus_rdata = widen(status);
      REG_PEND: bus_rdata = widen(pend);
      REG_MODE: bus_rdata = widen(mode_q);
      REG_POL:  bus_rdata = widen(pol_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign out_val  = val_q;
  assign dir      = dir_q;
  assign ien      = ien_q;
  assign edge_sel = mode_q;
  assign pol      = pol_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [N_PINS-1:0] pin_sync, status, evt;
  logic [N_PINS-1:0] out_val, dir, ien, edge_sel, pol, clr_mask;

  // reset asserts at once, deasserts after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gpio_sync2 #(.W(N_PINS)) sync_i (
    .clk(clk), .rst_n(rst_sync_n), .d_in(pin_in), .d_out(pin_sync)
  );

  gpio_regfile #(.N_PINS(N_PINS)) regs_i (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_sync(pin_sync), .status(status),
    .out_val(out_val), .dir(dir), .ien(ien),
    .edge_sel(edge_sel), .pol(pol), .clr_mask(clr_mask)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_pin_detect det_i (
      .clk(clk), .rst_n(rst_sync_n), .cur(pin_sync[i]),
      .edge_mode(edge_sel[i]), .pol(pol[i]), .clr(clr_mask[i]),
      .evt(evt[i]), .status(status[i])
    );
  end

  assign pin_out = out_val;
  assign pin_oe  = ~dir;
  assign irq_o   = |(status & ien);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [IDX_W-1:0]  bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_PINS-1:0] pin_out,
  input logic              irq_o,
  input logic [N_PINS-1:0] ien,
  input logic [N_PINS-1:0] edge_sel,
  input logic [N_PINS-1:0] clr_mask,
  input logic [N_PINS-1:0] evt,
  input logic [N_PINS-1:0] status
);
  logic val_wr;
  assign val_wr = bus_sel && bus_wr && (bus_addr == REG_VAL);

  a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
    val_wr |=> (pin_out == $past(bus_wdata[N_PINS-1:0])));

  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien != '0));

  for (genvar i = 0; i < N_PINS; i++) begin : g_bit
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && status[i] && !clr_mask[i]) |=> status[i]);

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && clr_mask[i] && !evt[i]) |=> !status[i]);

    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[i] && evt[i]) |=> status[i]);
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_out(pin_out),
  .irq_o(irq_o), .ien(ien), .edge_sel(edge_sel), .clr_mask(clr_mask),
  .evt(evt), .status(status)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  localparam int NP = 4;
  localparam logic [31:0] ALL = 32'hF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic        irq_o;
  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.N_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_stat(input string tag, input logic [31:0] exp, input logic [31:0] en);
    logic [31:0] d;
    rd(3'd3, d);
    check({tag, " status"}, d, exp);
    rd(3'd4, d);
    check("R7 pending", d, exp & en);
    check("R8 irq_o", {31'd0, irq_o}, {31'd0, |(exp & en)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0;
    repeat (3) @(posedge clk);
    // R1: register values while reset is held
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset reg", d, 32'd0);
    end
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);
    check("R1 pin_oe", 32'(pin_oe), ALL);
    check("R1 pin_out", 32'(pin_out), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R2 / R3: direction and value paths
    wr(3'd0, 32'hA);
    check("R3 pin_out", 32'(pin_out), 32'hA);
    rd(3'd0, d);
    check("R3 read outputs", d, 32'hA);
    pin_in = 4'h5;
    wr(3'd1, 32'h3);
    repeat (3) @(posedge clk);
    check("R2 pin_oe mixed", 32'(pin_oe), 32'hC);
    rd(3'd0, d);
    check("R3 read mixed", d, 32'h9);
    wr(3'd1, ALL);
    check("R2 pin_oe inputs", 32'(pin_oe), 32'h0);
    check("R2 pin_out kept", 32'(pin_out), 32'hA);
    rd(3'd0, d);
    check("R3 read inputs", d, 32'h5);
    // R11: upper bits read zero
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d);
    check("R11 ien width", d, ALL);
    wr(3'd2, 32'h0);
    rd(3'd5, d);
    check("R6 clear reads zero", d, 32'd0);
    pin_in = '0;
    repeat (4) @(posedge clk);

    // sweep: every pin, mode and polarity
    for (int p = 0; p < NP; p++) begin
      for (int em = 0; em < 2; em++) begin
        for (int pl = 0; pl < 2; pl++) begin
          logic [31:0] bit_p, en, s0, s1, s2, s3;
          bit_p = 32'd1 << p;
          en = bit_p;
          wr(3'd6, em ? bit_p : 32'd0);
          wr(3'd7, (pl ? bit_p : 32'd0) | (ALL & ~bit_p));
          wr(3'd2, en);
          repeat (3) @(posedge clk);
          wr(3'd5, ALL);
          s0 = (em == 0 && pl == 0) ? bit_p : 32'd0;
          chk_stat(em ? "R5 idle" : "R4 idle", s0, en);
          // rising pin
          @(negedge clk); pin_in = NP'(bit_p);
          @(posedge clk); @(posedge clk);
          rd(3'd3, d);
          check("R10 early", d, s0);
          @(posedge clk);
          s1 = em ? (pl ? s0 : bit_p) : (pl ? bit_p : 32'd0);
          chk_stat(em ? "R5 rise" : "R4 high", s1, en);
          // falling pin
          @(negedge clk); pin_in = '0;
          repeat (3) @(posedge clk);
          s2 = em ? bit_p : (pl ? 32'd0 : bit_p);
          chk_stat(em ? "R5 fall" : "R4 low", s2, en);
          // zero bits of a clear have no effect
          wr(3'd5, ALL & ~bit_p);
          chk_stat("R6 zero bits", s2, en);
          // R9: status and pending are read-only
          wr(3'd3, 32'd0);
          wr(3'd4, 32'd0);
          chk_stat("R9 read-only", s2, en);
          wr(3'd5, bit_p);
          s3 = em ? 32'd0 : (pl ? 32'd0 : bit_p);
          chk_stat(em ? "R6 cleared" : "R4 reassert", s3, en);
        end
      end
    end

    // R6: edge and clear on the same edge, edge wins
    wr(3'd6, 32'h1);
    wr(3'd7, 32'hE);
    wr(3'd2, 32'h1);
    repeat (3) @(posedge clk);
    wr(3'd5, ALL);
    chk_stat("R6 pre", 32'd0, 32'h1);
    @(negedge clk); pin_in = 4'h1;
    @(posedge clk); @(posedge clk);
    wr(3'd5, 32'h1);
    chk_stat("R6 event wins", 32'h1, 32'h1);
    wr(3'd5, 32'h1);
    chk_stat("R6 later clear", 32'h0, 32'h1);
    // R7: status recorded without enable
    wr(3'd2, 32'h0);
    @(negedge clk); pin_in = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk); pin_in = 4'h1;
    repeat (3) @(posedge clk);
    chk_stat("R7 unenabled", 32'h1, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule